// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block builds the word that a flash device returns on a read while an internal program or erase is running, while an erase is suspended, and for a short window after an operation finishes. A command decoder and a busy timer report the current operation: program busy, erase busy, erase suspended, and the region under suspension. This block combines that state with the read address, the stored array word and a read strobe. It produces the read data word and an active-low ready/busy flag.

Bits 7, 6 and 2 of the read word carry the status codes. Bit 7 is the polling bit, bit 6 is the primary toggle bit and bit 2 is the secondary toggle bit. All other bits always pass the array word through. The two toggle bits are flip-flops. They advance only when a read completes, so host software sees them change from one read to the next. The secondary toggle separates a region that is actively erasing from one that is suspended. After an operation completes, the status encoding stays selected for a programmable number of cycles before array data returns.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset both toggle flip-flops are 0 and no settle window is open. With no operation active, `rd_data` equals `arr_data` and `rdy_busy_n` is 1.
- R2: While `busy_prog` is 1, bit 7 of `rd_data` is the inverse of `prog_d7`. Every bit other than 7, 6 and 2 always equals the same bit of `arr_data`.
- R3: While `busy_erase` is 1 and `busy_prog` is 0, bit 7 of `rd_data` is 0.
- R4: While a program or an erase is busy, bit 6 inverts in the cycle after each cycle with `rd_strb` high. It holds its value in every other case.
- R5: Bit 2 inverts after each strobed read taken during an erase, or during a suspended-region read with no program busy. During a program it holds.
- R6: When `erase_susp` is 1, nothing is busy and the read hits the suspended region, bit 7 is 1 and bit 6 is 1. Bit 2 shows the secondary toggle and `rdy_busy_n` is 1. A hit means that `rd_addr` and `susp_addr` agree in bits AW-1 down to REGION_LSB.
- R7: During suspension, a read that misses the suspended region returns `arr_data` unchanged, provided no settle window is open.
- R8: A program busy during suspension overrides the region compare. The block shows the program encoding and `rdy_busy_n` is 0.
- R9: `rdy_busy_n` is 0 exactly while `busy_prog` or `busy_erase` is 1.
- R10: When all busy flags fall, status stays selected for SETTLE cycles, counting the first idle cycle. During that window bit 7 shows the true programmed bit (after a program) or 1 (after an erase), and bits 6 and 2 hold. After the window `arr_data` returns.
- R11: An erase that stops because it entered suspension opens no settle window. A new busy operation ends any open window at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_prog | input | 1 | Internal program in progress |
| busy_erase | input | 1 | Internal erase in progress |
| erase_susp | input | 1 | An erase is suspended |
| susp_addr | input | AW | Any address inside the suspended region |
| rd_addr | input | AW | Read address |
| rd_strb | input | 1 | A read completes this cycle |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| arr_data | input | DW | Stored array word at `rd_addr` |
| rd_data | output | DW | Read word with the status encoding applied |
| rdy_busy_n | output | 1 | Low while an operation is busy |

## Verification
A corrupted toggle flip-flop shows up on bit 6 or bit 2 on the next clock. It then stays wrong through every later read, because the bits only invert. A wrong settle count or a wrong last-operation flag shows up on the cycle where array data should return, or should stay hidden. It also shows as a wrong polling bit within the window. Each clock, the bench compares the whole read word and the ready flag against a behavioural model. The stimulus walks through program, erase, suspend-hit, suspend-miss, program-in-suspend, resume and a settle window cut short by a new operation.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic [2:0] {
    MODE_ARRAY,
    MODE_PROG,
    MODE_ERASE,
    MODE_SUSP_HIT,
    MODE_SETTLE
  } wstat_mode_e;

  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned TOG2_BIT = 2;
endpackage

// File: rtl/wstat_region_match.sv
module wstat_region_match #(
  parameter int unsigned AW  = 18,
  parameter int unsigned LSB = 11
) (
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          hit
);
  localparam int unsigned RW = AW - LSB;

  logic [RW-1:0] reg_a;
  logic [RW-1:0] reg_b;

  always_comb begin
    reg_a = addr_a[AW-1:LSB];
    reg_b = addr_b[AW-1:LSB];
    hit   = (reg_a == reg_b);
  end
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic strb,
  input  logic adv_pri,
  input  logic adv_sec,
  output logic q_pri,
  output logic q_sec
);
  logic en_pri;
  logic en_sec;
  logic q_pri_nx;
  logic q_sec_nx;

  always_comb begin
    en_pri   = strb && adv_pri;
    en_sec   = strb && adv_sec;
    q_pri_nx = ~q_pri;
    q_sec_nx = ~q_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_pri <= 1'b0;
    end else if (en_pri) begin
      q_pri <= q_pri_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sec <= 1'b0;
    end else if (en_sec) begin
      q_sec <= q_sec_nx;
    end
  end

  // R4
  pri_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && adv_pri) |=> (q_pri != $past(q_pri)));

  // R4
  pri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb && adv_pri) |=> $stable(q_pri));

  // R5
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb && adv_sec) |=> $stable(q_sec));
endmodule

// File: rtl/wstat_settle.sv
module wstat_settle #(
  parameter int unsigned SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_prog,
  input  logic busy_erase,
  input  logic erase_susp,
  input  logic prog_d7,
  output logic settling,
  output logic done_d7
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          last_erase_q, last_erase_nx;
  logic          pd7_q, pd7_nx;
  logic          busy;

  always_comb begin
    busy          = busy_prog || busy_erase;
    last_erase_nx = last_erase_q;
    pd7_nx        = pd7_q;
    if (busy_prog) begin
      last_erase_nx = 1'b0;
      pd7_nx        = prog_d7;
    end else if (busy_erase) begin
      last_erase_nx = 1'b1;
    end
    if (busy) begin
      cnt_nx = LOAD;
    end else if (erase_susp && last_erase_q) begin
      cnt_nx = '0;
    end else if (cnt_q != '0) begin
      cnt_nx = cnt_q - 1'b1;
    end else begin
      cnt_nx = cnt_q;
    end
    settling = (cnt_q != '0) && !busy && !(erase_susp && last_erase_q);
    done_d7  = last_erase_q ? 1'b1 : pd7_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      last_erase_q <= 1'b0;
      pd7_q        <= 1'b0;
    end else begin
      cnt_q        <= cnt_nx;
      last_erase_q <= last_erase_nx;
      pd7_q        <= pd7_nx;
    end
  end

  // R10
  settle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_prog || busy_erase) |=> (cnt_q == LOAD));

  // R10
  settle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busy_prog || busy_erase) && !(erase_susp && last_erase_q) && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R11
  settle_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busy_prog || busy_erase) && erase_susp && last_erase_q) |=> (cnt_q == '0));
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import wstat_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned AW         = 18,
  parameter int unsigned REGION_LSB = 11,
  parameter int unsigned SETTLE     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_prog,
  input  logic          busy_erase,
  input  logic          erase_susp,
  input  logic [AW-1:0] susp_addr,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_strb,
  input  logic          prog_d7,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rdy_busy_n
);
  logic        hit;
  logic        susp_hit;
  logic        tog_pri, tog_sec;
  logic        adv_pri, adv_sec;
  logic        settling, done_d7;
  wstat_mode_e mode;

  wstat_region_match #(.AW(AW), .LSB(REGION_LSB)) u_match (
    .addr_a (rd_addr),
    .addr_b (susp_addr),
    .hit    (hit)
  );

  always_comb begin
    susp_hit = erase_susp && hit;
    adv_pri  = busy_prog || busy_erase;
    adv_sec  = (busy_erase && !busy_prog) || (susp_hit && !busy_prog);
  end

  wstat_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (rd_strb),
    .adv_pri (adv_pri),
    .adv_sec (adv_sec),
    .q_pri   (tog_pri),
    .q_sec   (tog_sec)
  );

  wstat_settle #(.SETTLE(SETTLE)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_prog  (busy_prog),
    .busy_erase (busy_erase),
    .erase_susp (erase_susp),
    .prog_d7    (prog_d7),
    .settling   (settling),
    .done_d7    (done_d7)
  );

  always_comb begin
    if (busy_prog)       mode = MODE_PROG;
    else if (busy_erase) mode = MODE_ERASE;
    else if (susp_hit)   mode = MODE_SUSP_HIT;
    else if (settling)   mode = MODE_SETTLE;
    else                 mode = MODE_ARRAY;
  end

  always_comb begin
    rd_data    = arr_data;
    rdy_busy_n = !(busy_prog || busy_erase);
    case (mode)
      MODE_PROG: begin
        rd_data[POLL_BIT] = ~prog_d7;
        rd_data[TOG_BIT]  = tog_pri;
        rd_data[TOG2_BIT] = tog_sec;
      end
      MODE_ERASE: begin
        rd_data[POLL_BIT] = 1'b0;
        rd_data[TOG_BIT]  = tog_pri;
        rd_data[TOG2_BIT] = tog_sec;
      end
      MODE_SUSP_HIT: begin
        rd_data[POLL_BIT] = 1'b1;
        rd_data[TOG_BIT]  = 1'b1;
        rd_data[TOG2_BIT] = tog_sec;
      end
      MODE_SETTLE: begin
        rd_data[POLL_BIT] = done_d7;
        rd_data[TOG_BIT]  = tog_pri;
        rd_data[TOG2_BIT] = tog_sec;
      end
      default: ;
    endcase
  end

  // R8
  prog_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_prog && erase_susp) |-> (rd_data[POLL_BIT] == ~prog_d7 && !rdy_busy_n));

  // R6
  susp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_susp && hit && !busy_prog && !busy_erase)
      |-> (rd_data[POLL_BIT] && rd_data[TOG_BIT] && rdy_busy_n));

  // R2
  pass_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:8] == arr_data[DW-1:8]);
endmodule

// File: tb/sim_flash_wstat_gen.sv
module sim_flash_wstat_gen;
  localparam int DW = 16, AW = 18, LSB = 11, SETTLE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busy_prog = 0, busy_erase = 0, erase_susp = 0, rd_strb = 0, prog_d7 = 0;
  logic [AW-1:0] susp_addr = '0, rd_addr = '0;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rdy_busy_n;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_wstat_gen #(.DW(DW), .AW(AW), .REGION_LSB(LSB), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .busy_prog(busy_prog), .busy_erase(busy_erase),
    .erase_susp(erase_susp), .susp_addr(susp_addr), .rd_addr(rd_addr),
    .rd_strb(rd_strb), .prog_d7(prog_d7), .arr_data(arr_data),
    .rd_data(rd_data), .rdy_busy_n(rdy_busy_n)
  );

  // behavioural reference state
  bit m6 = 0, m2 = 0, m_er = 0, m_pd7 = 0;
  int m_left = 0;

  function automatic bit in_region();
    return (rd_addr >> LSB) == (susp_addr >> LSB);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m6 = 0; m2 = 0; m_er = 0; m_pd7 = 0; m_left = 0;
    end else begin
      bool_upd();
    end
  end

  task automatic bool_upd();
    bit busy = busy_prog | busy_erase;
    bit old_er = m_er;
    if (rd_strb && busy) m6 = !m6;
    if (rd_strb && !busy_prog && (busy_erase || (erase_susp && in_region()))) m2 = !m2;
    if (busy_prog) begin m_er = 0; m_pd7 = prog_d7; end
    else if (busy_erase) m_er = 1;
    if (busy) m_left = SETTLE;
    else if (erase_susp && old_er) m_left = 0;
    else if (m_left > 0) m_left--;
  endtask

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [DW-1:0] e;
      string tag;
      e = arr_data;
      tag = "R7";
      if (busy_prog) begin
        e[7] = ~prog_d7; e[6] = m6; e[2] = m2;
        tag = erase_susp ? "R8" : "R2/R4";
      end else if (busy_erase) begin
        e[7] = 0; e[6] = m6; e[2] = m2; tag = "R3/R5";
      end else if (erase_susp && in_region()) begin
        e[7] = 1; e[6] = 1; e[2] = m2; tag = "R6";
      end else if (m_left > 0 && !(erase_susp && m_er)) begin
        e[7] = m_er ? 1'b1 : m_pd7; e[6] = m6; e[2] = m2; tag = "R10";
      end else if (!erase_susp) tag = "R11/R1";
      check(tag, rd_data, e);
      check("R9", {15'd0, rdy_busy_n}, {15'd0, !(busy_prog | busy_erase)});
    end
  end

  task automatic cyc(int n, bit strb_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      arr_data = DW'($urandom);
      rd_strb  = strb_every ? 1'b1 : 1'($urandom);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state with idle inputs
    arr_data = 16'hA5C3;
    #1 check("R1", rd_data, 16'hA5C3);
    check("R1", {15'd0, rdy_busy_n}, 16'd1);
    cyc(6, 0);
    // program, bit7 = 1
    prog_d7 = 1; busy_prog = 1; cyc(9, 1); cyc(6, 0);
    busy_prog = 0; cyc(SETTLE + 4, 1);
    // erase
    busy_erase = 1; cyc(11, 1); cyc(5, 0);
    busy_erase = 0; cyc(SETTLE + 3, 1);
    // erase then suspend
    busy_erase = 1; cyc(5, 1);
    busy_erase = 0; erase_susp = 1; susp_addr = 18'h0_1A05;
    rd_addr = 18'h0_1B00; cyc(6, 1);          // R6 hit
    rd_addr = 18'h2_0000; cyc(6, 1);          // R7 miss, R11 no window
    // program in suspend, bit7 = 0
    prog_d7 = 0; busy_prog = 1; cyc(7, 1);    // R8
    busy_prog = 0; cyc(3, 1);                 // R10 after program
    rd_addr = 18'h0_1800; cyc(4, 1);          // R6 priority over window
    rd_addr = 18'h3_0000; cyc(SETTLE, 0);
    // resume, finish, interrupt window
    erase_susp = 0; busy_erase = 1; cyc(6, 1);
    busy_erase = 0; cyc(3, 1);
    prog_d7 = 1; busy_prog = 1; cyc(4, 1);    // R11 window cut
    busy_prog = 0; cyc(SETTLE + 5, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule